// File: doc/BRIEF.md
# Wake-up interrupt controller

This block keeps watch over the interrupt lines while the processor sleeps with its clocks stopped. When the processor enters a low-power state, the main interrupt controller presents a vector. The vector marks every line that is both enabled and of high enough priority to be serviced at once. The block takes a snapshot of that vector on the sleep-entry strobe. It then arms itself.

While armed, any line that is set in the snapshot and goes high raises a wake request. The request comes straight from that line through logic alone, so no clock edge is needed to produce it. Each line also has a sticky cause bit that records a hit once a clock runs. The cause bits show which lines woke the processor. They stay set until the processor returns to run and acknowledges the wake. The acknowledge clears the snapshot and all cause bits together.

Priority arbitration and vectoring stay in the main interrupt controller. This block only decides whether to wake and records why.

Top module: `wake_irq_ctrl`

## Requirements
- R1: When `sleep_i` is high in the run state and `ack_i` is low, the block stores `elig_i` as the wake mask on that clock edge and is armed from the next cycle.
- R2: A line whose mask bit is 0 never sets its cause bit and never raises `wake_o`. A change of `elig_i` after capture has no effect.
- R3: While armed, a masked line that is high appears in `cause_o` and raises `wake_o` in the same cycle, with no clock edge needed.
- R4: A cause bit stays set after its line goes low, until `ack_i`.
- R5: When several masked lines assert, at the same time or at different times, every one of them is recorded in `cause_o`. `wake_o` is high exactly when any bit of `cause_o` is set.
- R6: `ack_i` clears the mask and all cause bits and returns the block to the run state. `wake_o` is low from the next cycle, and later interrupts do not wake the block until the next sleep entry.
- R7: When `sleep_i` and `ack_i` are high in the same cycle, the acknowledge wins and the block does not arm.
- R8: `sleep_i` while armed is ignored: the mask is not taken again and the cause bits are kept.
- R9: In the run state, interrupt lines have no effect on `cause_o` or `wake_o`.
- R10: After reset, `wake_o` and `cause_o` are 0 and the block is in the run state.
- R11: Arming with an all-zero mask never raises `wake_o`, whatever the interrupt lines do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, used only to update the stored state |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | NUM_LINES | Interrupt line levels |
| elig_i | input | NUM_LINES | Enabled lines of sufficient priority, from the interrupt controller |
| sleep_i | input | 1 | Low-power entry strobe |
| ack_i | input | 1 | Wake acknowledge from the running processor |
| wake_o | output | 1 | Wake request |
| cause_o | output | NUM_LINES | Lines that caused the wake |

## Verification
The bench builds the block with `NUM_LINES = 8`. This keeps every mask pattern small enough that all-zero, all-one, sparse and edge-bit masks are reached by directed steps and by a random phase. With eight lines, the random phase often lands on sleep and acknowledge in the same cycle, re-entry while armed, and lines that are eligible but not masked. A behavioural model compares `wake_o` and `cause_o` with its own values on every cycle. These include the same-cycle path from a line to the wake request.

// File: rtl/wic_pkg.sv
package wic_pkg;
  typedef enum logic {
    WIC_RUN   = 1'b0,
    WIC_SLEEP = 1'b1
  } wic_state_e;
endpackage

// File: rtl/wic_ctrl.sv
module wic_ctrl
  import wic_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_i,
  input  logic ack_i,
  output logic capture_o,
  output logic clear_o,
  output logic armed_o
);
  wic_state_e state_q, state_d;

  // ack dominates; entry only from run
  assign clear_o   = ack_i;
  assign capture_o = (state_q == WIC_RUN) && sleep_i && !ack_i;
  assign armed_o   = (state_q == WIC_SLEEP);

  always_comb begin
    state_d = state_q;
    if (clear_o)        state_d = WIC_RUN;
    else if (capture_o) state_d = WIC_SLEEP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= WIC_RUN;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/wic_line.sv
module wic_line (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic capture_i,
  input  logic clear_i,
  input  logic armed_i,
  input  logic elig_i,
  input  logic irq_i,
  output logic mask_o,
  output logic cause_o
);
  logic mask_q, hit_q, hit_now;

  // level path: usable with clocks stopped
  assign hit_now = armed_i && mask_q && irq_i;
  assign cause_o = hit_q || hit_now;
  assign mask_o  = mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= 1'b0;
      hit_q  <= 1'b0;
    end else if (clear_i) begin
      mask_q <= 1'b0;
      hit_q  <= 1'b0;
    end else if (capture_i) begin
      mask_q <= elig_i;
      hit_q  <= 1'b0;
    end else if (hit_now) begin
      hit_q  <= 1'b1;
    end
  end
endmodule

// File: rtl/wake_irq_ctrl.sv
module wake_irq_ctrl #(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_i,
  input  logic [NUM_LINES-1:0] elig_i,
  input  logic                 sleep_i,
  input  logic                 ack_i,
  output logic                 wake_o,
  output logic [NUM_LINES-1:0] cause_o
);
  localparam int LastLine = NUM_LINES - 1;

  logic                 capture, clear, armed;
  logic [LastLine:0]    mask_q;

  wic_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sleep_i  (sleep_i),
    .ack_i    (ack_i),
    .capture_o(capture),
    .clear_o  (clear),
    .armed_o  (armed)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    wic_line u_line (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .capture_i(capture),
      .clear_i  (clear),
      .armed_i  (armed),
      .elig_i   (elig_i[g]),
      .irq_i    (irq_i[g]),
      .mask_o   (mask_q[g]),
      .cause_o  (cause_o[g])
    );
  end

  assign wake_o = |cause_o;
endmodule

// File: rtl/wic_chk.sv
module wic_chk #(
  parameter int NUM_LINES = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_LINES-1:0] irq_i,
  input logic [NUM_LINES-1:0] elig_i,
  input logic                 sleep_i,
  input logic                 ack_i,
  input logic                 armed,
  input logic [NUM_LINES-1:0] mask_q,
  input logic                 wake_o,
  input logic [NUM_LINES-1:0] cause_o
);
  a_r1_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i && !ack_i && !armed) |=> (armed && mask_q == $past(elig_i)));

  a_r2_outside_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_o & ~mask_q) == '0);

  a_r3_level_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && |(mask_q & irq_i)) |-> wake_o);

  a_r4_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ack_i && wake_o) |=> (wake_o && ((cause_o & $past(cause_o)) == $past(cause_o))));

  a_r6_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> (!armed && mask_q == '0 && !wake_o));

  a_r7_ack_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i && ack_i) |=> !armed);

  a_r8_no_recapture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !ack_i) |=> $stable(mask_q));

  a_r9_quiet_in_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |-> !wake_o);
endmodule

bind wake_irq_ctrl wic_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .irq_i  (irq_i),
  .elig_i (elig_i),
  .sleep_i(sleep_i),
  .ack_i  (ack_i),
  .armed  (armed),
  .mask_q (mask_q),
  .wake_o (wake_o),
  .cause_o(cause_o)
);

// File: tb/wake_irq_ctrl_tb.sv
module wake_irq_ctrl_tb;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] irq = '0, elig = '0;
  logic         sleep = 1'b0, ack = 1'b0;
  logic         wake;
  logic [N-1:0] cause;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  // reference model state
  bit           m_armed = 1'b0;
  logic [N-1:0] m_mask = '0, m_cause = '0;

  always #2 clk = ~clk;

  wake_irq_ctrl #(.NUM_LINES(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .elig_i(elig),
    .sleep_i(sleep), .ack_i(ack), .wake_o(wake), .cause_o(cause)
  );

  function automatic logic [N-1:0] model_cause();
    return m_cause | (m_armed ? (m_mask & irq) : '0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_armed = 1'b0; m_mask = '0; m_cause = '0;
    end else if (ack) begin
      m_armed = 1'b0; m_mask = '0; m_cause = '0;
    end else if (!m_armed && sleep) begin
      m_armed = 1'b1; m_mask = elig; m_cause = '0;
    end else if (m_armed) begin
      m_cause = m_cause | (m_mask & irq);
    end
  end

  // per-cycle comparison against the model (R3, R5)
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      checks++;
      if (cause !== model_cause()) begin
        errors++;
        $display("FAIL R3 cause per-cycle: got %h exp %h", cause, model_cause());
      end
      checks++;
      if (wake !== (|model_cause())) begin
        errors++;
        $display("FAIL R5 wake per-cycle: got %b exp %b", wake, |model_cause());
      end
    end
  end

  task automatic chk(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [N-1:0] i, input logic [N-1:0] e, input logic s, input logic a);
    @(negedge clk);
    irq = i; elig = e; sleep = s; ack = a;
    #2;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk("R10 reset wake", {{(N-1){1'b0}}, wake}, '0);
    chk("R10 reset cause", cause, '0);
    rst_n = 1'b1;

    drive(8'hFF, 8'hFF, 0, 0);
    chk("R9 irq in run", cause, '0);
    chk("R9 wake in run", {{(N-1){1'b0}}, wake}, '0);

    drive(8'h00, 8'h0A, 1, 0);          // enter sleep with mask 0x0A
    drive(8'h05, 8'hFF, 0, 0);
    chk("R2 unmasked lines", cause, '0);
    drive(8'h02, 8'hFF, 0, 0);
    chk("R3 same-cycle cause", cause, 8'h02);
    chk("R3 same-cycle wake", {{(N-1){1'b0}}, wake}, 8'h01);
    drive(8'h00, 8'h00, 0, 0);
    chk("R4 sticky cause", cause, 8'h02);
    drive(8'h08, 8'h00, 0, 0);
    chk("R5 second line", cause, 8'h0A);
    drive(8'h00, 8'hFF, 1, 0);          // re-entry while armed
    drive(8'h10, 8'h00, 0, 0);
    chk("R8 no recapture", cause, 8'h0A);
    drive(8'h00, 8'h00, 0, 1);
    drive(8'h00, 8'h00, 0, 0);
    chk("R6 ack clears cause", cause, '0);
    drive(8'h02, 8'h00, 0, 0);
    chk("R6 mask cleared", {{(N-1){1'b0}}, wake}, '0);

    drive(8'h00, 8'hFF, 1, 1);          // sleep and ack together
    drive(8'hFF, 8'h00, 0, 0);
    chk("R7 ack wins", cause, '0);

    drive(8'h00, 8'h00, 1, 0);          // arm with empty mask
    drive(8'hFF, 8'hFF, 0, 0);
    drive(8'hAA, 8'hFF, 0, 0);
    chk("R11 empty mask", {{(N-1){1'b0}}, wake}, '0);
    drive(8'h00, 8'h00, 0, 1);

    drive(8'h00, 8'h81, 1, 0);
    drive(8'h80, 8'h00, 0, 0);
    chk("R1 top line captured", cause, 8'h80);
    drive(8'h7F, 8'h00, 0, 0);
    chk("R1 bottom line captured", cause, 8'h81);
    drive(8'h00, 8'h00, 0, 1);

    for (int k = 0; k < 400; k++) begin
      automatic logic [N-1:0] ri = N'($urandom);
      automatic logic [N-1:0] re = N'($urandom);
      drive(ri & N'($urandom), re, ($urandom % 6) == 0, ($urandom % 9) == 0);
    end

    drive(8'h00, 8'h00, 0, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule